// File: doc/BRIEF.md
# Privilege and Virtualization Mode Controller

This block holds the current privilege level and the virtualization bit of a hart that has the hypervisor extension. It moves the hart between modes when a trap is taken and when a return instruction retires. Every move writes privilege and virtualization together in one clock edge. The same edge saves the outgoing pair as the previous-mode copy and raises a TLB-flush pulse.

Trap requests arrive with their cause, an interrupt flag and the delegation decision already made upstream. The block selects the matching trap-vector base and computes the handler address. It also drives the supervisor-bank select, which steers CSR side effects to the virtual or the non-virtual supervisor registers. The block also produces the status-field clear commands that the return instructions imply. CSR storage, address translation and interrupt arbitration stay outside the block.

Top module: `priv_mode_ctrl`

## Requirements
- R1: After reset, priv_o is machine (3), virt_o is 0, prev_priv_o is 3, prev_virt_o is 0, and tlb_flush_o and handler_pc_valid_o are 0. Level encodings are user=0, supervisor=1, machine=3.
- R2: An accepted event updates priv_o and virt_o at the next rising edge. At that same edge, prev_priv_o and prev_virt_o take the pair that was current before the edge.
- R3: The new virtualization bit is the requested bit ANDed with "new level is not machine", and is 0 when HAS_H is 0.
- R4: A requested level is legalized before use. The reserved value 2 becomes user, or machine if HAS_U is 0. Supervisor becomes user if HAS_S is 0.
- R5: tlb_flush_o is high for exactly the cycle after each event's edge, which is the first cycle the new mode is visible. It stays low when no event is accepted.
- R6: A trap with trap_to_vs_i set enters supervisor with virt_o=1. It uses vstvec_i, and s_bank_virt_o is 1 in the request cycle.
- R7: A trap with trap_to_hs_i set and trap_to_vs_i clear enters supervisor with virt_o=0 and uses stvec_i. s_bank_virt_o is 0 in the request cycle, even when virt_o is 1.
- R8: A trap with neither delegation flag set enters machine with virt_o=0 and uses mtvec_i.
- R9: handler_pc_o is the selected base with bit 0 cleared. When bit 0 of the base is 1 and trap_irq_i is 1, 4 times trap_cause_i is added. handler_pc_valid_o pulses with tlb_flush_o after a trap.
- R10: SRET enters supervisor if spp_i is 1 and user otherwise. If virt_o is 0 and HAS_H is set, the new virtualization bit is spv_i and spv_clear_o is 1 in the request cycle. If virt_o is 1, virtualization stays 1 and spv_clear_o stays 0.
- R11: MRET takes its level from mpp_i and its bit from mpv_i. mpv_clear_o is 1 in the request cycle. mpp_reset_o gives user (0) when HAS_U is set, else machine (3).
- R12: MNRET takes its level from mnpp_i and its bit from mnpv_i.
- R13: Priority is trap over MNRET over MRET over SRET. The losing strobes have no effect, and their clear outputs stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trap_valid_i | input | 1 | Trap request this cycle |
| trap_cause_i | input | CAUSE_W | Trap cause number |
| trap_irq_i | input | 1 | Trap is an interrupt |
| trap_to_vs_i | input | 1 | Trap delegated to virtual supervisor |
| trap_to_hs_i | input | 1 | Trap delegated to hypervisor-extended supervisor |
| mret_i | input | 1 | Machine return strobe |
| sret_i | input | 1 | Supervisor return strobe |
| mnret_i | input | 1 | Resumable-NMI return strobe |
| mpp_i | input | 2 | Machine saved previous level |
| mpv_i | input | 1 | Machine saved previous virtualization |
| spp_i | input | 1 | Supervisor saved previous level (1=supervisor) |
| spv_i | input | 1 | Hypervisor status saved previous virtualization |
| mnpp_i | input | 2 | NMI saved previous level |
| mnpv_i | input | 1 | NMI saved previous virtualization |
| mtvec_i | input | XLEN | Machine trap-vector base |
| stvec_i | input | XLEN | Non-virtual supervisor trap-vector base |
| vstvec_i | input | XLEN | Virtual supervisor trap-vector base |
| priv_o | output | 2 | Current privilege level |
| virt_o | output | 1 | Current virtualization bit |
| prev_priv_o | output | 2 | Level before the last update |
| prev_virt_o | output | 1 | Virtualization before the last update |
| handler_pc_o | output | XLEN | Trap handler address |
| handler_pc_valid_o | output | 1 | handler_pc_o is fresh this cycle |
| tlb_flush_o | output | 1 | TLB flush pulse |
| s_bank_virt_o | output | 1 | 1 selects the virtual supervisor CSR bank |
| spv_clear_o | output | 1 | Clear the hypervisor SPV field |
| mpv_clear_o | output | 1 | Clear the machine MPV field |
| mpp_reset_o | output | 2 | Value to write into the machine MPP field on MRET |

## Verification
The mode pair, the previous-mode copies, handler_pc_o, handler_pc_valid_o and tlb_flush_o are registered. They are due in the cycle after the edge that samples the request. The bench drives each request after a falling edge and reads these outputs one time unit after the next rising edge. One cycle later it confirms that the flush pulse has dropped. The bank select and the clear commands are combinational on the request. They are sampled one time unit after the inputs are driven, before the rising edge that consumes them.

// File: rtl/priv_mode_pkg.sv
package priv_mode_pkg;
  typedef enum logic [1:0] {
    LVL_U   = 2'd0,
    LVL_S   = 2'd1,
    LVL_RSV = 2'd2,
    LVL_M   = 2'd3
  } lvl_e;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_VS   = 2'd1,
    TGT_HS   = 2'd2,
    TGT_M    = 2'd3
  } tgt_e;
endpackage

// File: rtl/priv_next_mode.sv
module priv_next_mode
  import priv_mode_pkg::*;
#(
  parameter bit HAS_H = 1'b1
) (
  input  logic       trap_valid_i,
  input  logic       trap_to_vs_i,
  input  logic       trap_to_hs_i,
  input  logic       mret_i,
  input  logic       sret_i,
  input  logic       mnret_i,
  input  logic [1:0] mpp_i,
  input  logic       mpv_i,
  input  logic       spp_i,
  input  logic       spv_i,
  input  logic [1:0] mnpp_i,
  input  logic       mnpv_i,
  input  logic       virt_q_i,
  output logic       upd_o,
  output logic [1:0] req_lvl_o,
  output logic       req_virt_o,
  output tgt_e       tgt_o,
  output logic       spv_clear_o,
  output logic       mpv_clear_o,
  output logic       bank_virt_o
);
  always_comb begin
    upd_o       = 1'b0;
    req_lvl_o   = LVL_M;
    req_virt_o  = 1'b0;
    tgt_o       = TGT_NONE;
    spv_clear_o = 1'b0;
    mpv_clear_o = 1'b0;
    if (trap_valid_i) begin
      upd_o = 1'b1;
      if (trap_to_vs_i) begin
        tgt_o      = TGT_VS;
        req_lvl_o  = LVL_S;
        req_virt_o = 1'b1;
      end else if (trap_to_hs_i) begin
        tgt_o     = TGT_HS;
        req_lvl_o = LVL_S;
      end else begin
        tgt_o = TGT_M;
      end
    end else if (mnret_i) begin
      upd_o      = 1'b1;
      req_lvl_o  = mnpp_i;
      req_virt_o = mnpv_i;
    end else if (mret_i) begin
      upd_o       = 1'b1;
      req_lvl_o   = mpp_i;
      req_virt_o  = mpv_i;
      mpv_clear_o = 1'b1;
    end else if (sret_i) begin
      upd_o     = 1'b1;
      req_lvl_o = spp_i ? LVL_S : LVL_U;
      if (virt_q_i) begin
        req_virt_o = 1'b1;
      end else begin
        req_virt_o  = HAS_H & spv_i;
        spv_clear_o = HAS_H;
      end
    end
  end

  // trap writes go to the bank of its target; otherwise follow the current mode
  assign bank_virt_o = trap_valid_i ? trap_to_vs_i : virt_q_i;
endmodule

// File: rtl/priv_legalize.sv
module priv_legalize
  import priv_mode_pkg::*;
#(
  parameter bit HAS_U = 1'b1,
  parameter bit HAS_S = 1'b1,
  parameter bit HAS_H = 1'b1
) (
  input  logic [1:0] req_lvl_i,
  input  logic       req_virt_i,
  output logic [1:0] lvl_o,
  output logic       virt_o
);
  localparam logic [1:0] LOWEST = HAS_U ? LVL_U : LVL_M;

  always_comb begin
    unique case (req_lvl_i)
      LVL_M:   lvl_o = LVL_M;
      LVL_S:   lvl_o = HAS_S ? LVL_S : LOWEST;
      default: lvl_o = LOWEST;
    endcase
  end

  assign virt_o = HAS_H & req_virt_i & (lvl_o != LVL_M);
endmodule

// File: rtl/priv_vec_calc.sv
module priv_vec_calc
  import priv_mode_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 6
) (
  input  tgt_e              tgt_i,
  input  logic [XLEN-1:0]   mtvec_i,
  input  logic [XLEN-1:0]   stvec_i,
  input  logic [XLEN-1:0]   vstvec_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic              irq_i,
  output logic [XLEN-1:0]   pc_o
);
  localparam int PAD_W = XLEN - CAUSE_W - 2;

  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offs;

  always_comb begin
    unique case (tgt_i)
      TGT_VS:  base = vstvec_i;
      TGT_HS:  base = stvec_i;
      default: base = mtvec_i;
    endcase
  end

  assign offs = (base[0] && irq_i) ? {{PAD_W{1'b0}}, cause_i, 2'b00} : '0;
  assign pc_o = {base[XLEN-1:1], 1'b0} + offs;
endmodule

// File: rtl/priv_mode_ctrl.sv
module priv_mode_ctrl
  import priv_mode_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 6,
  parameter bit HAS_U   = 1'b1,
  parameter bit HAS_S   = 1'b1,
  parameter bit HAS_H   = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               trap_valid_i,
  input  logic [CAUSE_W-1:0] trap_cause_i,
  input  logic               trap_irq_i,
  input  logic               trap_to_vs_i,
  input  logic               trap_to_hs_i,
  input  logic               mret_i,
  input  logic               sret_i,
  input  logic               mnret_i,
  input  logic [1:0]         mpp_i,
  input  logic               mpv_i,
  input  logic               spp_i,
  input  logic               spv_i,
  input  logic [1:0]         mnpp_i,
  input  logic               mnpv_i,
  input  logic [XLEN-1:0]    mtvec_i,
  input  logic [XLEN-1:0]    stvec_i,
  input  logic [XLEN-1:0]    vstvec_i,
  output logic [1:0]         priv_o,
  output logic               virt_o,
  output logic [1:0]         prev_priv_o,
  output logic               prev_virt_o,
  output logic [XLEN-1:0]    handler_pc_o,
  output logic               handler_pc_valid_o,
  output logic               tlb_flush_o,
  output logic               s_bank_virt_o,
  output logic               spv_clear_o,
  output logic               mpv_clear_o,
  output logic [1:0]         mpp_reset_o
);
  logic            upd;
  logic [1:0]      req_lvl;
  logic            req_virt;
  tgt_e            tgt;
  logic [1:0]      new_lvl;
  logic            new_virt;
  logic [XLEN-1:0] vec_pc;

  logic [1:0]      lvl_q, prev_lvl_q;
  logic            virt_q, prev_virt_q;
  logic            flush_q, pc_valid_q;
  logic [XLEN-1:0] pc_q;

  priv_next_mode #(.HAS_H(HAS_H)) u_next (
    .trap_valid_i (trap_valid_i),
    .trap_to_vs_i (trap_to_vs_i),
    .trap_to_hs_i (trap_to_hs_i),
    .mret_i       (mret_i),
    .sret_i       (sret_i),
    .mnret_i      (mnret_i),
    .mpp_i        (mpp_i),
    .mpv_i        (mpv_i),
    .spp_i        (spp_i),
    .spv_i        (spv_i),
    .mnpp_i       (mnpp_i),
    .mnpv_i       (mnpv_i),
    .virt_q_i     (virt_q),
    .upd_o        (upd),
    .req_lvl_o    (req_lvl),
    .req_virt_o   (req_virt),
    .tgt_o        (tgt),
    .spv_clear_o  (spv_clear_o),
    .mpv_clear_o  (mpv_clear_o),
    .bank_virt_o  (s_bank_virt_o)
  );

  priv_legalize #(.HAS_U(HAS_U), .HAS_S(HAS_S), .HAS_H(HAS_H)) u_legal (
    .req_lvl_i  (req_lvl),
    .req_virt_i (req_virt),
    .lvl_o      (new_lvl),
    .virt_o     (new_virt)
  );

  priv_vec_calc #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_vec (
    .tgt_i    (tgt),
    .mtvec_i  (mtvec_i),
    .stvec_i  (stvec_i),
    .vstvec_i (vstvec_i),
    .cause_i  (trap_cause_i),
    .irq_i    (trap_irq_i),
    .pc_o     (vec_pc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q       <= LVL_M;
      virt_q      <= 1'b0;
      prev_lvl_q  <= LVL_M;
      prev_virt_q <= 1'b0;
      flush_q     <= 1'b0;
      pc_valid_q  <= 1'b0;
      pc_q        <= '0;
    end else begin
      flush_q    <= upd;
      pc_valid_q <= trap_valid_i;
      if (upd) begin
        prev_lvl_q  <= lvl_q;
        prev_virt_q <= virt_q;
        lvl_q       <= new_lvl;
        virt_q      <= new_virt;
      end
      if (trap_valid_i) pc_q <= vec_pc;
    end
  end

  assign priv_o             = lvl_q;
  assign virt_o             = virt_q;
  assign prev_priv_o        = prev_lvl_q;
  assign prev_virt_o        = prev_virt_q;
  assign handler_pc_o       = pc_q;
  assign handler_pc_valid_o = pc_valid_q;
  assign tlb_flush_o        = flush_q;
  assign mpp_reset_o        = HAS_U ? LVL_U : LVL_M;
endmodule

// File: rtl/priv_mode_chk.sv
module priv_mode_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       trap_valid_i,
  input logic       trap_to_vs_i,
  input logic       mret_i,
  input logic       sret_i,
  input logic       mnret_i,
  input logic [1:0] priv_o,
  input logic       virt_o,
  input logic [1:0] prev_priv_o,
  input logic       prev_virt_o,
  input logic       handler_pc_valid_o,
  input logic       tlb_flush_o,
  input logic       s_bank_virt_o,
  input logic       spv_clear_o,
  input logic       mpv_clear_o
);
  p_mach_no_virt_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priv_o == 2'd3) |-> !virt_o);

  p_no_reserved_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    priv_o != 2'd2);

  p_flush_on_change_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priv_o != $past(priv_o) || virt_o != $past(virt_o)) |-> tlb_flush_o);

  p_prev_copy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlb_flush_o |-> (prev_priv_o == $past(priv_o) && prev_virt_o == $past(virt_o)));

  p_flush_after_event_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_valid_i || mret_i || sret_i || mnret_i) |=> tlb_flush_o);

  p_vs_enter_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_valid_i && trap_to_vs_i) |=> (priv_o == 2'd1 && virt_o));

  p_hs_bank_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_valid_i && !trap_to_vs_i) |-> !s_bank_virt_o);

  p_pc_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    handler_pc_valid_o |-> tlb_flush_o);

  p_trap_wins_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i |-> (!spv_clear_o && !mpv_clear_o));
endmodule

bind priv_mode_ctrl priv_mode_chk u_chk (
  .clk_i              (clk_i),
  .rst_ni             (rst_ni),
  .trap_valid_i       (trap_valid_i),
  .trap_to_vs_i       (trap_to_vs_i),
  .mret_i             (mret_i),
  .sret_i             (sret_i),
  .mnret_i            (mnret_i),
  .priv_o             (priv_o),
  .virt_o             (virt_o),
  .prev_priv_o        (prev_priv_o),
  .prev_virt_o        (prev_virt_o),
  .handler_pc_valid_o (handler_pc_valid_o),
  .tlb_flush_o        (tlb_flush_o),
  .s_bank_virt_o      (s_bank_virt_o),
  .spv_clear_o        (spv_clear_o),
  .mpv_clear_o        (mpv_clear_o)
);

// File: tb/priv_mode_ctrl_tb.sv
`timescale 1ns/1ps
module priv_mode_ctrl_tb;
  localparam int XLEN = 32;
  localparam int CW   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          trap_valid, trap_irq, to_vs, to_hs, mret, sret, mnret;
  logic [CW-1:0] cause;
  logic [1:0]    mpp, mnpp;
  logic          mpv, spp, spv, mnpv;
  logic [XLEN-1:0] mtvec, stvec, vstvec;
  logic [1:0]    priv, prev_priv, mpp_reset;
  logic          virt, prev_virt, pc_valid, flush, bank_virt, spv_clr, mpv_clr;
  logic [XLEN-1:0] hpc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  priv_mode_ctrl #(.XLEN(XLEN), .CAUSE_W(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .trap_valid_i(trap_valid), .trap_cause_i(cause), .trap_irq_i(trap_irq),
    .trap_to_vs_i(to_vs), .trap_to_hs_i(to_hs),
    .mret_i(mret), .sret_i(sret), .mnret_i(mnret),
    .mpp_i(mpp), .mpv_i(mpv), .spp_i(spp), .spv_i(spv),
    .mnpp_i(mnpp), .mnpv_i(mnpv),
    .mtvec_i(mtvec), .stvec_i(stvec), .vstvec_i(vstvec),
    .priv_o(priv), .virt_o(virt), .prev_priv_o(prev_priv), .prev_virt_o(prev_virt),
    .handler_pc_o(hpc), .handler_pc_valid_o(pc_valid), .tlb_flush_o(flush),
    .s_bank_virt_o(bank_virt), .spv_clear_o(spv_clr), .mpv_clear_o(mpv_clr),
    .mpp_reset_o(mpp_reset)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    trap_valid = 0; trap_irq = 0; to_vs = 0; to_hs = 0;
    mret = 0; sret = 0; mnret = 0; cause = '0;
  endtask

  // check registered mode after the consuming edge, then the pulse drop
  task automatic after_edge(input string req, input logic [1:0] ep, input logic ev,
                            input logic [1:0] epp, input logic epv);
    @(posedge clk); #1;
    chk({req, " priv"}, priv, ep);
    chk({req, " virt"}, virt, ev);
    chk({req, " prev_priv R2"}, prev_priv, epp);
    chk({req, " prev_virt R2"}, prev_virt, epv);
    chk({req, " flush R5"}, flush, 1'b1);
  endtask

  task automatic pulse_drop(input string req);
    @(negedge clk); idle_inputs();
    @(posedge clk); #1;
    chk({req, " flush low R5"}, flush, 1'b0);
    chk({req, " pc_valid low R9"}, pc_valid, 1'b0);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 priv", priv, 2'd3);
    chk("R1 virt", virt, 1'b0);
    chk("R1 prev_priv", prev_priv, 2'd3);
    chk("R1 prev_virt", prev_virt, 1'b0);
    chk("R1 flush", flush, 1'b0);
    chk("R1 pc_valid", pc_valid, 1'b0);
  endtask

  task automatic t_mret_to_vu();
    @(negedge clk); mret = 1; mpp = 2'd0; mpv = 1;
    #1;
    chk("R11 mpv_clear", mpv_clr, 1'b1);
    chk("R11 mpp_reset", mpp_reset, 2'd0);
    after_edge("R11 mret", 2'd0, 1'b1, 2'd3, 1'b0);
    pulse_drop("R11");
  endtask

  task automatic t_vs_trap();
    @(negedge clk); trap_valid = 1; to_vs = 1; trap_irq = 1; cause = 6'd5; vstvec = 32'h2001;
    #1;
    chk("R6 bank virt", bank_virt, 1'b1);
    after_edge("R6 vs trap", 2'd1, 1'b1, 2'd0, 1'b1);
    chk("R9 vs vectored pc", hpc, 32'h2014);
    chk("R9 pc_valid", pc_valid, 1'b1);
    pulse_drop("R6");
  endtask

  task automatic t_hs_trap();
    @(negedge clk); trap_valid = 1; to_hs = 1; trap_irq = 0; cause = 6'd8; stvec = 32'h3001;
    #1;
    chk("R7 bank nonvirt while virt", bank_virt, 1'b0);
    after_edge("R7 hs trap", 2'd1, 1'b0, 2'd1, 1'b1);
    chk("R9 exception no offset", hpc, 32'h3000);
    pulse_drop("R7");
  endtask

  task automatic t_sret_from_hs();
    @(negedge clk); sret = 1; spp = 0; spv = 1;
    #1;
    chk("R10 spv_clear", spv_clr, 1'b1);
    after_edge("R10 sret nonvirt", 2'd0, 1'b1, 2'd1, 1'b0);
    pulse_drop("R10");
  endtask

  task automatic t_sret_from_vs();
    // reach VS first
    @(negedge clk); trap_valid = 1; to_vs = 1; vstvec = 32'h2000;
    after_edge("R6 vs trap2", 2'd1, 1'b1, 2'd0, 1'b1);
    @(negedge clk); idle_inputs(); sret = 1; spp = 1; spv = 0;
    #1;
    chk("R10 no spv_clear when virt", spv_clr, 1'b0);
    after_edge("R10 sret virt", 2'd1, 1'b1, 2'd1, 1'b1);
    pulse_drop("R10b");
  endtask

  task automatic t_m_trap();
    @(negedge clk); trap_valid = 1; trap_irq = 1; cause = 6'd7; mtvec = 32'h101;
    #1;
    chk("R7 bank nonvirt on m trap", bank_virt, 1'b0);
    after_edge("R8 m trap", 2'd3, 1'b0, 2'd1, 1'b1);
    chk("R9 m vectored pc", hpc, 32'h11C);
    pulse_drop("R8");
  endtask

  task automatic t_mret_machine_virt();
    @(negedge clk); mret = 1; mpp = 2'd3; mpv = 1;
    after_edge("R3 mret to m", 2'd3, 1'b0, 2'd3, 1'b0);
    pulse_drop("R3");
  endtask

  task automatic t_mret_reserved();
    @(negedge clk); mret = 1; mpp = 2'd2; mpv = 1;
    after_edge("R4 reserved lvl", 2'd0, 1'b1, 2'd3, 1'b0);
    pulse_drop("R4");
  endtask

  task automatic t_mnret();
    @(negedge clk); mnret = 1; mnpp = 2'd1; mnpv = 1;
    after_edge("R12 mnret", 2'd1, 1'b1, 2'd0, 1'b1);
    pulse_drop("R12");
  endtask

  task automatic t_priority();
    @(negedge clk); trap_valid = 1; mret = 1; sret = 1; mpp = 2'd0; mpv = 1; spv = 1; mtvec = 32'h400;
    #1;
    chk("R13 mpv_clear suppressed", mpv_clr, 1'b0);
    chk("R13 spv_clear suppressed", spv_clr, 1'b0);
    after_edge("R13 trap wins", 2'd3, 1'b0, 2'd1, 1'b1);
    chk("R13 pc from mtvec", hpc, 32'h400);
    pulse_drop("R13");
    @(negedge clk); mret = 1; sret = 1; mpp = 2'd1; mpv = 0;
    #1;
    chk("R13 sret loses spv_clear", spv_clr, 1'b0);
    after_edge("R13 mret over sret", 2'd1, 1'b0, 2'd3, 1'b0);
    pulse_drop("R13b");
  endtask

  task automatic t_idle();
    @(negedge clk); idle_inputs(); mpp = 2'd0; spp = 1;
    repeat (3) @(posedge clk);
    #1;
    chk("R5 no flush idle", flush, 1'b0);
    chk("R5 priv stable", priv, 2'd1);
    chk("R5 virt stable", virt, 1'b0);
  endtask

  initial begin
    idle_inputs();
    mpp = 0; mpv = 0; spp = 0; spv = 0; mnpp = 0; mnpv = 0;
    mtvec = '0; stvec = '0; vstvec = '0;
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_mret_to_vu();
    t_vs_trap();
    t_hs_trap();
    t_sret_from_hs();
    t_sret_from_vs();
    t_m_trap();
    t_mret_machine_virt();
    t_mret_reserved();
    t_mnret();
    t_priority();
    t_idle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule